// File: doc/BRIEF.md
# Per-Context Interrupt Priority Selector

This block arbitrates among the interrupt sources that one target context can see. Each cycle it takes three source bit vectors (pending, claimed and per-context enable), a 3-bit priority for every source and the context's threshold. From these it picks the winning source and raises the context's interrupt request. A source takes part only when it is pending, enabled and not already claimed. Its priority must also be strictly above the threshold. When several sources share the top priority, the lowest source ID wins. ID 0 is reserved to mean "no winner".

A 2-bit mode input routes the request onto the external-interrupt line for machine level or for supervisor level. The remaining modes leave both lines low. The block holds no register state of its own besides its output stage. The claim and complete side effects belong to the surrounding controller, which feeds the updated claimed vector back in. All outputs are registered: they reflect the inputs sampled at the previous rising clock edge.

Top module: `ctx_prio_select`

## Requirements
- R1: A source takes part only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1. Bit i of each vector belongs to source i.
- R2: A taking-part source competes only when its priority (bits 3i+2..3i of `src_prio_i`) is strictly greater than `thresh_i`. A priority equal to the threshold is masked.
- R3: Of the competing sources, `win_id_o` gives the one with the highest priority. On equal priorities the lowest source ID wins.
- R4: `win_id_o` is 0 when no source competes. Source 0 is never returned, whatever its inputs.
- R5: Sources with ID at or above the parameter `NUM_SRC` never take part, even though their bits exist in the 32-bit word vectors.
- R6: `irq_req_o` is 1 exactly when `win_id_o` is nonzero.
- R7: A source with priority 0 never competes. With threshold 7, no source competes.
- R8: Mode encoding is 0 = user, 1 = supervisor, 2 = hypervisor, 3 = machine. In machine mode `irq_m_o` follows the request. In supervisor mode `irq_s_o` follows the request. In the other two modes both lines stay 0.
- R9: The outputs are registered. They show the result for the inputs present at the previous rising edge, and all outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_mode_i | input | 2 | Privilege mode of this context |
| thresh_i | input | 3 | Context priority threshold |
| pend_i | input | 32*NUM_WORDS | Pending bit per source |
| claim_i | input | 32*NUM_WORDS | Claimed bit per source |
| en_i | input | 32*NUM_WORDS | Enable bit per source for this context |
| src_prio_i | input | 3*NUM_SRC | Priority per source, 3 bits each |
| irq_req_o | output | 1 | Context interrupt request |
| irq_m_o | output | 1 | Machine external-interrupt line |
| irq_s_o | output | 1 | Supervisor external-interrupt line |
| win_id_o | output | ID_W | Winning source ID, 0 for none |

## Verification
The bench builds the block with `NUM_SRC` = 40. The vectors therefore span two 32-bit words, of which only the lower eight bits of the second word are real sources. This lets the tests set bits 40 to 63 and confirm that they are ignored. It also puts both a low-word and a high-word source into the same contest, so the tie-break can be checked across a word boundary and at the top source, ID 39.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;
    localparam int PRIO_W = 3;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_HYPER = 2'd2,
        MODE_MACH  = 2'd3
    } ctx_mode_e;
endpackage

// File: rtl/ctx_sel_qualify.sv
module ctx_sel_qualify #(
    parameter int NUM_SRC = 40,
    parameter int NUM_BITS = 64
) (
    input  logic [NUM_BITS-1:0] pend_i,
    input  logic [NUM_BITS-1:0] claim_i,
    input  logic [NUM_BITS-1:0] en_i,
    output logic [NUM_SRC-1:0]  live_o
);
    logic [NUM_BITS-1:0] raw;
    assign raw = pend_i & ~claim_i & en_i;

    // ID 0 is reserved for "none"; IDs 1..NUM_SRC-1 are real sources
    assign live_o = {raw[NUM_SRC-1:1], 1'b0};

    logic unused_bits;
    generate
        if (NUM_BITS > NUM_SRC) begin : g_tail
            assign unused_bits = raw[0] ^ (^raw[NUM_BITS-1:NUM_SRC]);
        end else begin : g_notail
            assign unused_bits = raw[0];
        end
    endgenerate
endmodule

// File: rtl/ctx_sel_pick.sv
module ctx_sel_pick
    import ctx_sel_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ID_W = 6
) (
    input  logic [NUM_SRC-1:0]        live_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [ID_W-1:0]           best_id_o,
    output logic [PRIO_W-1:0]         best_prio_o
);
    // Ascending scan; replace only on strictly greater priority,
    // so equal priorities keep the lower ID.
    always_comb begin
        best_prio_o = thresh_i;
        best_id_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (live_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_prio_o)) begin
                best_prio_o = prio_i[i*PRIO_W +: PRIO_W];
                best_id_o   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/ctx_prio_select.sv
module ctx_prio_select
    import ctx_sel_pkg::*;
#(
    parameter int NUM_SRC = 40,
    localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W,
    localparam int NUM_BITS = NUM_WORDS * WORD_W,
    localparam int ID_W = (NUM_SRC > 2) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                ctx_mode_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    input  logic [NUM_BITS-1:0]       pend_i,
    input  logic [NUM_BITS-1:0]       claim_i,
    input  logic [NUM_BITS-1:0]       en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    output logic                      irq_req_o,
    output logic                      irq_m_o,
    output logic                      irq_s_o,
    output logic [ID_W-1:0]           win_id_o
);
    logic [NUM_SRC-1:0] live;
    logic [ID_W-1:0]    pick_id;
    logic [PRIO_W-1:0]  pick_prio;
    ctx_mode_e          mode;
    logic               seen_edge;

    assign mode = ctx_mode_e'(ctx_mode_i);

    ctx_sel_qualify #(.NUM_SRC(NUM_SRC), .NUM_BITS(NUM_BITS)) u_qual (
        .pend_i (pend_i),
        .claim_i(claim_i),
        .en_i   (en_i),
        .live_o (live)
    );

    ctx_sel_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .live_i     (live),
        .prio_i     (src_prio_i),
        .thresh_i   (thresh_i),
        .best_id_o  (pick_id),
        .best_prio_o(pick_prio)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_id_o  <= '0;
            irq_req_o <= 1'b0;
            irq_m_o   <= 1'b0;
            irq_s_o   <= 1'b0;
            seen_edge <= 1'b0;
        end else begin
            seen_edge <= 1'b1;
            win_id_o  <= pick_id;
            irq_req_o <= (pick_id != '0);
            irq_m_o   <= 1'b0;
            irq_s_o   <= 1'b0;
            unique case (mode)
                MODE_MACH:  irq_m_o <= (pick_id != '0);
                MODE_SUPER: irq_s_o <= (pick_id != '0);
                MODE_USER, MODE_HYPER: ;
            endcase
        end
    end

    // R1: the picked source is pending, unclaimed and enabled
    a_r1_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_id != '0) |-> (pend_i[pick_id] && !claim_i[pick_id] && en_i[pick_id]));

    // R2: the winning priority is strictly above the threshold
    a_r2_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_id != '0) |-> (src_prio_i[pick_id*PRIO_W +: PRIO_W] > thresh_i));

    // R5: the winner always lies inside the source range
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(win_id_o) < NUM_SRC);

    // R6: the request and the ID agree every cycle
    a_r6_req_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o == (win_id_o != '0));

    // R8: at most one line, and only while a request is up
    a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_m_o, irq_s_o}) && ((irq_m_o || irq_s_o) -> irq_req_o));

    // R8: machine mode routes the request to the machine line
    a_r8_mach_route: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(ctx_mode_i) == 2'd3) |-> (irq_m_o == irq_req_o));
endmodule

// File: tb/sim_ctx_prio_select.sv
module sim_ctx_prio_select;
    localparam int N  = 40;
    localparam int NB = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd3;
    logic [2:0]    thr = 3'd0;
    logic [NB-1:0] pend = '0, clm = '0, en = '0;
    logic [N*3-1:0] prio = '0;
    logic          req, irq_m, irq_s;
    logic [IW-1:0] wid;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ctx_prio_select #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ctx_mode_i(mode), .thresh_i(thr),
        .pend_i(pend), .claim_i(clm), .en_i(en), .src_prio_i(prio),
        .irq_req_o(req), .irq_m_o(irq_m), .irq_s_o(irq_s), .win_id_o(wid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        pend = '0; clm = '0; en = '0; prio = '0; thr = 3'd0; mode = 2'd3;
    endtask

    // drive at negedge, result registered on next posedge, sample at following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_id(input string tag, input int id);
        step();
        check({tag, " id"}, int'(wid), id);
        check({"R6 ", tag, " req"}, int'(req), int'(id != 0));
    endtask

    task automatic set_src(input int id, input int p);
        pend[id] = 1'b1; en[id] = 1'b1; prio[id*3 +: 3] = 3'(p);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_src(5, 4);
        step();
        check("R9 reset id", int'(wid), 0);
        check("R9 reset lines", int'({req, irq_m, irq_s}), 0);
        rst_n = 1'b1;
        expect_id("R9 after reset", 5);
        clear_all();
    endtask

    task automatic t_eligibility();
        clear_all();
        set_src(3, 2);
        expect_id("R1 single", 3);
        clm[3] = 1'b1;
        expect_id("R1 claimed", 0);
        clm[3] = 1'b0; en[3] = 1'b0;
        expect_id("R1 disabled", 0);
        en[3] = 1'b1; pend[3] = 1'b0;
        expect_id("R1 not pending", 0);
    endtask

    task automatic t_threshold();
        clear_all();
        set_src(7, 3);
        thr = 3'd3;
        expect_id("R2 equal masked", 0);
        thr = 3'd2;
        expect_id("R2 above", 7);
        set_src(9, 7);
        thr = 3'd7;
        expect_id("R7 thresh 7", 0);
        clear_all();
        set_src(4, 0);
        expect_id("R7 prio zero", 0);
    endtask

    task automatic t_ordering();
        clear_all();
        set_src(12, 5);
        set_src(35, 5);
        set_src(20, 3);
        expect_id("R3 tie lower id", 12);
        prio[35*3 +: 3] = 3'd6;
        expect_id("R3 higher prio wins", 35);
        set_src(39, 7);
        expect_id("R3 top source", 39);
        clm[39] = 1'b1;
        expect_id("R3 next best", 35);
    endtask

    task automatic t_reserved();
        clear_all();
        set_src(0, 7);
        expect_id("R4 source zero", 0);
        pend[NB-1:N] = '1; en[NB-1:N] = '1;
        expect_id("R5 beyond range", 0);
        set_src(1, 1);
        expect_id("R5 with real", 1);
    endtask

    task automatic t_modes();
        clear_all();
        set_src(6, 2);
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            step();
            check("R8 m line", int'(irq_m), int'(m == 3));
            check("R8 s line", int'(irq_s), int'(m == 1));
            check("R8 req", int'(req), 1);
        end
        mode = 2'd1; en[6] = 1'b0;
        step();
        check("R8 s idle", int'(irq_s), 0);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_eligibility();
                t_threshold();
                t_ordering();
                t_reserved();
                t_modes();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule